// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether an incoming Ethernet frame is kept or dropped, based only on its 48-bit destination address. Software sets it up through a small 16-bit word register port. Through that port it writes a station (own) address, up to four exact-match multicast group addresses and a control word that holds two mode bits. One bit makes the filter accept every frame. The other accepts every frame whose destination has the group bit set, and software uses it when it needs more groups than there are slots.

The receive datapath presents the destination address together with a one-cycle valid strobe once the first six bytes of a frame have been captured. One clock later the block produces a decision pulse. The pulse carries an accept flag, a code that tells which rule matched and, for a slot match, which slot it was. A slot loaded with all ones in every word is treated as empty and never matches.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset no decision is pending, every multicast slot word reads 0xFFFF (empty), and the station words and the control word read 0x0000.
- R2: The station address occupies word addresses 0, 1 and 2. Word k holds destination byte 2k in bits 7:0 and byte 2k+1 in bits 15:8, and byte 0 is the first byte on the wire. On `rx_da`, byte n sits in bits 8n+7:8n. A destination equal to the station address is accepted with rule code 1.
- R3: Multicast slot s (0 to 3) occupies word addresses 3+3s, 4+3s and 5+3s, with the same byte order as the station address. A destination equal to a non-empty slot is accepted with rule code 2, and `flt_slot` gives the lowest matching slot index.
- R4: A slot whose three words are all 0xFFFF never matches. A slot with at least one word not equal to 0xFFFF is active.
- R5: When control word (address 15) bit 5 is set, every frame is accepted. Rule code 5 is reported when no more specific rule matches.
- R6: When control bit 8 is set, a frame whose group bit is set is accepted with rule code 4 when no more specific rule matches. The group bit is bit 0 of destination byte 0. A frame with the group bit clear gains nothing from control bit 8.
- R7: The destination FF:FF:FF:FF:FF:FF is always accepted, with rule code 3 unless the station address matches it.
- R8: Rule priority is station (1), slot (2), broadcast (3), accept-all-multicast (4), promiscuous (5). A rejected frame reports accept 0, rule code 0 and slot 0.
- R9: `flt_valid` goes high for exactly one cycle, on the clock edge after each cycle in which `rx_da_vld` is high. Strobes in consecutive cycles give decisions in consecutive cycles.
- R10: A register write in the same cycle as an address strobe does not affect that frame's decision. It affects the next frame.
- R11: The control word stores all 16 bits and reads them back. Writing it with the mode bits cleared and then with new mode bits leaves every other bit as written, and only bits 5 and 8 change filtering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | ADDR_W | Word address for write and read |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the addressed word (combinational) |
| rx_da_vld | input | 1 | Destination address valid strobe |
| rx_da | input | 48 | Destination address, byte 0 in bits 7:0 |
| flt_valid | output | 1 | Decision valid pulse |
| flt_accept | output | 1 | Frame accepted |
| flt_rule | output | 3 | Matched rule code (see R8) |
| flt_slot | output | $clog2(N_SLOTS) | Matching slot index for rule code 2 |

## Verification
The two functions that can fall in the same cycle are a register write and an address strobe. The bench drives both on one clock edge, for example enabling promiscuous mode or loading a slot while a matching destination is presented. The scoreboard expects that frame to be judged with the old settings and the next frame with the new ones. Back-to-back strobes check that decisions arrive one per cycle in order, so the queue would expose a dropped or duplicated pulse.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
    localparam int WORD_W   = 16;
    localparam int MAC_W    = 48;
    localparam int WPA      = MAC_W / WORD_W;   // words per address

    typedef enum logic [2:0] {
        RULE_NONE    = 3'd0,
        RULE_STATION = 3'd1,
        RULE_SLOT    = 3'd2,
        RULE_BCAST   = 3'd3,
        RULE_ALLMC   = 3'd4,
        RULE_PROMISC = 3'd5
    } rule_e;
endpackage

// File: rtl/afilt_regs.sv
module afilt_regs #(
    parameter int N_SLOTS   = 4,
    parameter int ADDR_W    = 4,
    parameter int PROM_BIT  = 5,
    parameter int ALLMC_BIT = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [afilt_pkg::WORD_W-1:0]          wdata,
    output logic [afilt_pkg::WORD_W-1:0]          rdata,
    output logic [afilt_pkg::MAC_W-1:0]           station,
    output logic [N_SLOTS-1:0][afilt_pkg::MAC_W-1:0] slots,
    output logic                                  mode_prom,
    output logic                                  mode_allmc
);
    import afilt_pkg::*;

    localparam int NW       = WPA * (N_SLOTS + 1) + 1;
    localparam int CTRL_IDX = NW - 1;
    localparam int SLOT_LO  = WPA;
    localparam int SLOT_HI  = WPA * (N_SLOTS + 1) - 1;

    typedef struct packed {
        logic [NW-1:0][WORD_W-1:0] w;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && (int'(addr) < NW))
            regs_d.w[int'(addr)] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++)
                regs_q.w[i] <= (i >= SLOT_LO && i <= SLOT_HI) ? '1 : '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) < NW)
            rdata = regs_q.w[int'(addr)];
    end

    assign station    = {regs_q.w[2], regs_q.w[1], regs_q.w[0]};
    assign mode_prom  = regs_q.w[CTRL_IDX][PROM_BIT];
    assign mode_allmc = regs_q.w[CTRL_IDX][ALLMC_BIT];

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        assign slots[s] = {regs_q.w[SLOT_LO + WPA*s + 2],
                           regs_q.w[SLOT_LO + WPA*s + 1],
                           regs_q.w[SLOT_LO + WPA*s]};
    end

    // R11: without a write the register contents stay put
    a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_q));
endmodule

// File: rtl/afilt_slot_cmp.sv
module afilt_slot_cmp #(
    parameter int N_SLOTS = 4
) (
    input  logic [afilt_pkg::MAC_W-1:0]              da,
    input  logic [N_SLOTS-1:0][afilt_pkg::MAC_W-1:0] slots,
    output logic [N_SLOTS-1:0]                       hit
);
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_cmp
        logic active;
        assign active = (slots[s] != '1);
        assign hit[s] = active && (slots[s] == da);

        // R4: an empty slot never reports a hit
        always_comb begin
            a_r4_empty_slot_silent: assert (active || !hit[s]);
        end
    end
endmodule

// File: rtl/afilt_decide.sv
module afilt_decide #(
    parameter int N_SLOTS = 4,
    parameter int SLOT_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          da_vld,
    input  logic [afilt_pkg::MAC_W-1:0]   da,
    input  logic [afilt_pkg::MAC_W-1:0]   station,
    input  logic [N_SLOTS-1:0]            slot_hit,
    input  logic                          mode_prom,
    input  logic                          mode_allmc,
    output logic                          dec_valid,
    output logic                          dec_accept,
    output logic [2:0]                    dec_rule,
    output logic [SLOT_W-1:0]             dec_slot
);
    import afilt_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              accept;
        rule_e             rule;
        logic [SLOT_W-1:0] slot;
    } dec_t;

    dec_t dec_d, dec_q;
    logic [SLOT_W-1:0] low_hit;

    always_comb begin
        low_hit = '0;
        for (int s = N_SLOTS - 1; s >= 0; s--)
            if (slot_hit[s]) low_hit = SLOT_W'(s);
    end

    always_comb begin
        dec_d        = '0;
        dec_d.valid  = da_vld;
        dec_d.rule   = RULE_NONE;
        if (da_vld) begin
            if (da == station)              dec_d.rule = RULE_STATION;
            else if (|slot_hit) begin
                dec_d.rule = RULE_SLOT;
                dec_d.slot = low_hit;
            end
            else if (da == '1)              dec_d.rule = RULE_BCAST;
            else if (mode_allmc && da[0])   dec_d.rule = RULE_ALLMC;
            else if (mode_prom)             dec_d.rule = RULE_PROMISC;
            dec_d.accept = (dec_d.rule != RULE_NONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;
    assign dec_rule   = dec_q.rule;
    assign dec_slot   = dec_q.slot;

    // R9: one decision per strobe, one cycle later
    a_r9_strobe_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
        da_vld |=> dec_valid);
    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !da_vld |=> !dec_valid);
    // R5: promiscuous mode accepts everything
    a_r5_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (da_vld && mode_prom) |=> dec_accept);
    // R7: broadcast always accepted
    a_r7_bcast_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (da_vld && da == '1) |=> dec_accept);
    // R6: unicast never credited to accept-all-multicast
    a_r6_unicast_not_allmc: assert property (@(posedge clk) disable iff (!rst_n)
        (da_vld && !da[0]) |=> dec_rule != RULE_ALLMC);
    // R8: a reject carries the null rule code
    a_r8_reject_code: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |-> (dec_rule == RULE_NONE && dec_slot == '0));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
    parameter int N_SLOTS   = 4,
    parameter int ADDR_W    = 4,
    parameter int PROM_BIT  = 5,
    parameter int ALLMC_BIT = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [15:0]                 cfg_wdata,
    output logic [15:0]                 cfg_rdata,
    input  logic                        rx_da_vld,
    input  logic [47:0]                 rx_da,
    output logic                        flt_valid,
    output logic                        flt_accept,
    output logic [2:0]                  flt_rule,
    output logic [$clog2(N_SLOTS)-1:0]  flt_slot
);
    import afilt_pkg::*;

    localparam int SLOT_W = $clog2(N_SLOTS);

    logic [MAC_W-1:0]              station;
    logic [N_SLOTS-1:0][MAC_W-1:0] slots;
    logic [N_SLOTS-1:0]            slot_hit;
    logic                          mode_prom, mode_allmc;

    afilt_regs #(
        .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W),
        .PROM_BIT(PROM_BIT), .ALLMC_BIT(ALLMC_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .station(station),
        .slots(slots), .mode_prom(mode_prom), .mode_allmc(mode_allmc)
    );

    afilt_slot_cmp #(.N_SLOTS(N_SLOTS)) u_cmp (
        .da(rx_da), .slots(slots), .hit(slot_hit)
    );

    afilt_decide #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .da_vld(rx_da_vld), .da(rx_da),
        .station(station), .slot_hit(slot_hit),
        .mode_prom(mode_prom), .mode_allmc(mode_allmc),
        .dec_valid(flt_valid), .dec_accept(flt_accept),
        .dec_rule(flt_rule), .dec_slot(flt_slot)
    );
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb_top;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        rx_da_vld = 1'b0;
    logic [47:0] rx_da = '0;
    logic        flt_valid, flt_accept;
    logic [2:0]  flt_rule;
    logic [1:0]  flt_slot;

    always #2.5 clk = ~clk;

    rx_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rx_da_vld(rx_da_vld), .rx_da(rx_da),
        .flt_valid(flt_valid), .flt_accept(flt_accept),
        .flt_rule(flt_rule), .flt_slot(flt_slot)
    );

    typedef struct packed {
        logic       acc;
        logic [2:0] rule;
        logic [1:0] slot;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    int    n_chk = 0;
    int    n_bad = 0;
    logic [15:0] sh [16];
    logic  prev_vld = 1'b0;

    function automatic exp_t model(input logic [47:0] d);
        exp_t e;
        logic [47:0] st;
        e = '0;
        st = {sh[2], sh[1], sh[0]};
        if (d == st) e.rule = 3'd1;
        else begin
            for (int s = NS - 1; s >= 0; s--) begin
                logic [47:0] sl;
                sl = {sh[5+3*s], sh[4+3*s], sh[3+3*s]};
                if (sl != '1 && sl == d) begin
                    e.rule = 3'd2;
                    e.slot = 2'(s);
                end
            end
            if (e.rule == 3'd0) begin
                if (d == '1)                 e.rule = 3'd3;
                else if (sh[15][8] && d[0])  e.rule = 3'd4;
                else if (sh[15][5])          e.rule = 3'd5;
            end
        end
        e.acc = (e.rule != 3'd0);
        return e;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        sh[a] = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input logic [3:0] a, input logic [15:0] v, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, {16'h0, cfg_rdata}, {16'h0, v});
    endtask

    task automatic push_frame(input logic [47:0] d, input string req);
        rx_da_vld = 1'b1; rx_da = d;
        q_exp.push_back(model(d));
        q_tag.push_back(req);
    endtask

    task automatic frame(input logic [47:0] d, input string req);
        @(negedge clk);
        push_frame(d, req);
        @(negedge clk);
        rx_da_vld = 1'b0;
    endtask

    // frame and register write in the same cycle (R10)
    task automatic frame_and_write(input logic [47:0] d, input logic [3:0] a,
                                   input logic [15:0] v, input string req);
        @(negedge clk);
        push_frame(d, req);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        sh[a] = v;
        @(negedge clk);
        rx_da_vld = 1'b0; cfg_we = 1'b0;
    endtask

    always @(posedge clk) prev_vld <= rx_da_vld;

    // monitor: decisions must follow strobes by one cycle and match the queue
    always @(negedge clk) begin
        if (rst_n && (flt_valid || prev_vld)) begin
            check("R9 valid timing", {31'h0, flt_valid}, {31'h0, prev_vld});
            if (flt_valid) begin
                if (q_exp.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R9: actual=decision expected=none");
                end else begin
                    exp_t e;
                    string t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    check(t, {26'h0, flt_accept, flt_rule, flt_slot}, {26'h0, e});
                end
            end
        end
    end

    initial begin
        int wd = 0;
        while (wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) sh[i] = (i >= 3 && i <= 14) ? 16'hFFFF : 16'h0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 no decision", {31'h0, flt_valid}, 32'h0);
        rst_n = 1'b1;
        cfg_check(4'd0,  16'h0000, "R1 station word");
        cfg_check(4'd7,  16'hFFFF, "R1 slot word empty");
        cfg_check(4'd15, 16'h0000, "R1 control word");

        // R4: empty slots; all-ones is broadcast not slot; R7
        frame(48'hFFFF_FFFF_FFFF, "R4 R7 broadcast");

        // R2: station 00:00:60:00:00:01
        cfg_write(4'd0, 16'h0000);
        cfg_write(4'd1, 16'h0060);
        cfg_write(4'd2, 16'h0100);
        frame(48'h0100_0060_0000, "R2 station match");
        frame(48'h0200_0060_0000, "R8 unicast reject");
        frame(48'h0500_005E_0001, "R8 multicast no slot reject");

        // R3: slot 2 = 01:00:5e:00:00:05
        cfg_write(4'd9,  16'h0001);
        cfg_write(4'd10, 16'h005E);
        cfg_write(4'd11, 16'h0500);
        frame(48'h0500_005E_0001, "R3 slot2 match");
        cfg_write(4'd6, 16'h0001);
        cfg_write(4'd7, 16'h005E);
        cfg_write(4'd8, 16'h0500);
        frame(48'h0500_005E_0001, "R3 lowest slot wins");

        // R4: slot 3 with only partly all-ones is active
        cfg_write(4'd12, 16'hFFFF);
        cfg_write(4'd13, 16'hFFFF);
        cfg_write(4'd14, 16'hFEFF);
        frame(48'hFEFF_FFFF_FFFF, "R4 partial ones active");

        // R6: accept-all-multicast
        cfg_write(4'd15, 16'h0100);
        frame(48'h0700_005E_0001, "R6 allmc group");
        frame(48'h0200_0060_0000, "R6 allmc unicast reject");

        // R10: enable promisc in the same cycle as a unicast frame
        frame_and_write(48'h0300_0060_0000, 4'd15, 16'h0120, "R10 old settings");
        frame(48'h0300_0060_0000, "R5 R10 promisc next frame");

        // R8 priority: station beats promisc; back-to-back (R9)
        @(negedge clk);
        push_frame(48'h0100_0060_0000, "R8 station over promisc");
        @(negedge clk);
        push_frame(48'h0700_005E_0001, "R8 allmc over promisc");
        @(negedge clk);
        push_frame(48'h0500_005E_0001, "R9 back-to-back slot");
        @(negedge clk);
        rx_da_vld = 1'b0;

        // R10: slot change in the same cycle affects next frame only
        frame_and_write(48'h0500_005E_0001, 4'd6, 16'h1111, "R10 slot old");
        frame(48'h0500_005E_0001, "R10 slot new");

        // R11: control bits preserved around mode changes
        cfg_write(4'd15, 16'h800B & ~16'h0120);
        cfg_check(4'd15, 16'h800B, "R11 mode cleared others kept");
        cfg_write(4'd15, 16'h800B | 16'h0020);
        cfg_check(4'd15, 16'h802B, "R11 promisc set others kept");
        frame(48'h0900_0060_0000, "R11 R5 promisc only");
        cfg_write(4'd15, 16'h800B);
        frame(48'h0900_0060_0000, "R11 other bits no filtering effect");

        repeat (4) @(negedge clk);
        check("R9 queue drained", q_exp.size(), 32'h0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule